// File: doc/BRIEF.md
# Dual-Mode Adder / Register Cell

This block is a single configurable cell for an array of reconfigurable logic. It has three one-bit data inputs (`a`, `b`, `c`), a clock and a mode select, and it drives two one-bit outputs (`x`, `y`). With the mode select high, the cell is a combinational full adder. `x` carries the sum bit and `y` carries the carry bit. With the mode select low, the cell is a single D register. It samples `a` on the rising clock edge and presents the stored bit on `x`, while `y` is held at 0.

The mode select is an ordinary input that outside configuration logic drives. It may change in any cycle, and the outputs follow the new mode at once. The stored bit survives time spent in adder mode. Simple two-input gates come from tying `c` to a constant. The storage element has a synchronous, active-high reset. Two parameters set the reset behaviour: whether reset exists at all, and the value it loads.

Top module: `dmc_cell`

## Requirements
- R1: While `mode` = 1, `x` equals the exclusive-OR of `a`, `b` and `c` in the same cycle, for all eight input combinations.
- R2: While `mode` = 1, `y` is 1 exactly when at least two of `a`, `b`, `c` are 1, in the same cycle.
- R3: While `mode` = 0, `x` shows the value that `a` had at the most recent rising clock edge, so `a` appears on `x` one cycle later.
- R4: While `mode` = 0, `y` is 0 regardless of `a`, `b` and `c`.
- R5: When `rst` = 1 at a rising edge, the stored bit becomes `RESET_VAL` (default 0) in any mode. With `mode` = 0 this is visible on `x` after that edge.
- R6: Rising edges that occur while `mode` = 1 leave the stored bit unchanged. After a return to `mode` = 0, `x` shows the bit that was captured before the switch.
- R7: With `mode` = 1 and `c` tied to 0, `x` is `a` XOR `b` and `y` is `a` AND `b`. With `c` tied to 1, `x` is `a` XNOR `b` and `y` is `a` OR `b`.
- R8: A change of `mode` takes effect on `x` and `y` within the same cycle, with no clock edge and no reset needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the storage bit |
| rst | input | 1 | Synchronous active-high reset of the storage bit |
| mode | input | 1 | 1 = full-adder mode, 0 = register mode |
| a | input | 1 | Data input; also the register's D input |
| b | input | 1 | Data input (adder mode only) |
| c | input | 1 | Data input (adder mode only) |
| x | output | 1 | Sum bit in adder mode, stored bit in register mode |
| y | output | 1 | Carry bit in adder mode, 0 in register mode |

## Verification
Two functions can fall in the same cycle: a mode change and the contents of the storage bit.

The bench provokes this by capturing a 1 in register mode and then running several adder-mode edges with `a` = 0. It then drops `mode` between edges. The bench reads `x` before the next edge: it must already show the held 1, proving the switch is immediate and the hold took effect.

A reset asserted during adder mode also overlaps with the hold rule. The reset must win, and the bench judges this the same way after the return to register mode.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic {
      MODE_REG = 1'b0,
      MODE_ADD = 1'b1
   } cell_mode_e;
endpackage

// File: rtl/dmc_adder.sv
module dmc_adder (
   input  logic a,
   input  logic b,
   input  logic c,
   output logic sum,
   output logic carry
);
   logic ab_x;
   always_comb begin
      ab_x  = a ^ b;
      sum   = ab_x ^ c;
      carry = (a & b) | (c & ab_x);
   end
endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
   parameter bit RESET_EN  = 1'b1,
   parameter int RESET_VAL = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic d,
   output logic q
);
   localparam logic RST_BIT = RESET_VAL[0];

   if (RESET_VAL < 0 || RESET_VAL > 1) begin : g_bad_rst_val
      $error("dmc_store: RESET_VAL must be 0 or 1");
   end

   if (RESET_EN) begin : g_sync_rst
      always_ff @(posedge clk) begin
         if (rst)       q <= RST_BIT;
         else if (load) q <= d;
      end

      // R5
      rst_load_chk: assert property (@(posedge clk) rst |=> q == RST_BIT);
   end else begin : g_no_rst
      logic unused_rst;
      assign unused_rst = rst;
      always_ff @(posedge clk) begin
         if (load) q <= d;
      end
   end

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));

   // R3
   capture_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(d));
endmodule

// File: rtl/dmc_cell.sv
module dmc_cell #(
   parameter bit RESET_EN  = 1'b1,
   parameter int RESET_VAL = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic mode,
   input  logic a,
   input  logic b,
   input  logic c,
   output logic x,
   output logic y
);
   import dmc_pkg::*;

   cell_mode_e mode_e;
   logic       fa_sum;
   logic       fa_carry;
   logic       reg_q;
   logic       reg_load;

   assign mode_e   = cell_mode_e'(mode);
   assign reg_load = (mode_e == MODE_REG);

   dmc_adder u_adder (
      .a     (a),
      .b     (b),
      .c     (c),
      .sum   (fa_sum),
      .carry (fa_carry)
   );

   dmc_store #(
      .RESET_EN  (RESET_EN),
      .RESET_VAL (RESET_VAL)
   ) u_store (
      .clk  (clk),
      .rst  (rst),
      .load (reg_load),
      .d    (a),
      .q    (reg_q)
   );

   always_comb begin
      unique case (mode_e)
         MODE_ADD: begin
            x = fa_sum;
            y = fa_carry;
         end
         default: begin
            x = reg_q;
            y = 1'b0;
         end
      endcase
   end

   // R1
   sum_out_chk: assert property (@(posedge clk) disable iff (rst)
      mode |-> x == ((a + b + c) % 2 == 1));

   // R2
   carry_out_chk: assert property (@(posedge clk) disable iff (rst)
      mode |-> y == ((32'(a) + 32'(b) + 32'(c)) >= 2));

   // R4
   reg_y_low_chk: assert property (@(posedge clk) disable iff (rst)
      !mode |-> !y);

   // R3
   reg_delay_chk: assert property (@(posedge clk) disable iff (rst)
      !mode |=> (mode || x == $past(a)));
endmodule

// File: tb/dmc_cell_bench.sv
module dmc_cell_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst, mode, a, b, c;
   logic x, y;
   int   checks = 0;
   int   errors = 0;
   bit   done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmc_cell u_dmc_cell (
      .clk(clk), .rst(rst), .mode(mode),
      .a(a), .b(b), .c(c), .x(x), .y(y)
   );

   task automatic chk(input string req, input string what,
                      input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   // R5: reset clears stored bit, seen on x in register mode
   task automatic t_reset();
      settle(); rst = 1; mode = 0; a = 1; b = 1; c = 1;
      settle();
      chk("R5", "x after reset", x, 1'b0);
      chk("R4", "y after reset", y, 1'b0);
      rst = 0;
   endtask

   // R1, R2: all eight combinations
   task automatic t_adder();
      settle(); mode = 1;
      for (int i = 0; i < 8; i++) begin
         a = i[0]; b = i[1]; c = i[2];
         #1;
         chk("R1", $sformatf("sum abc=%0d", i), x, ^i[2:0]);
         chk("R2", $sformatf("carry abc=%0d", i), y,
             (int'(i[0]) + int'(i[1]) + int'(i[2])) >= 2);
         settle();
      end
   endtask

   // R7: derived gates
   task automatic t_gates();
      settle(); mode = 1;
      for (int i = 0; i < 4; i++) begin
         a = i[0]; b = i[1];
         c = 0; #1;
         chk("R7", "xor", x, i[0] ^ i[1]);
         chk("R7", "and", y, i[0] & i[1]);
         c = 1; #1;
         chk("R7", "xnor", x, ~(i[0] ^ i[1]));
         chk("R7", "or", y, i[0] | i[1]);
      end
   endtask

   // R3, R4: one-cycle delay of a onto x
   task automatic t_register();
      logic [7:0] pat = 8'b1011_0010;
      settle(); mode = 0; a = pat[0]; b = 1; c = 1;
      for (int i = 1; i < 8; i++) begin
         settle();
         chk("R3", $sformatf("delayed a step %0d", i), x, pat[i-1]);
         chk("R4", "y in register mode", y, 1'b0);
         a = pat[i];
         #1;
         chk("R3", "x stable between edges", x, pat[i-1]);
      end
   endtask

   // R6, R8: hold across adder mode and immediate switch back
   task automatic t_hold_switch();
      settle(); mode = 0; a = 1;
      settle(); chk("R3", "captured 1", x, 1'b1);
      mode = 1; a = 0; b = 0; c = 0; #1;
      chk("R8", "immediate switch to adder x", x, 1'b0);
      for (int i = 0; i < 3; i++) settle();
      mode = 0; #1;
      chk("R8", "immediate switch back", x, 1'b1);
      chk("R6", "held value", x, 1'b1);
      b = 1; c = 1; #1;
      chk("R4", "y zero with b,c high", y, 1'b0);
      mode = 1; #1;
      chk("R8", "carry appears on switch", y, 1'b1);
   endtask

   // R5: reset wins during adder mode
   task automatic t_reset_in_add();
      settle(); mode = 0; a = 1;
      settle(); mode = 1; rst = 1;
      settle(); rst = 0; mode = 0; a = 1; #1;
      chk("R5", "reset during adder mode", x, 1'b0);
   endtask

   initial begin
      rst = 1; mode = 0; a = 0; b = 0; c = 0;
      repeat (2) @(negedge clk);
      chk("R5", "initial reset x", x, 1'b0);
      rst = 0;
      t_reset();
      t_adder();
      t_gates();
      t_register();
      t_hold_switch();
      t_reset_in_add();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule